// File: doc/BRIEF.md
# Keypad Status and Key-Interrupt Unit

This block takes ten button lines and presents them to a 16-bit register bus as a key status word in which a pressed button reads as 0. The lines are brought into the clock domain by a synchronizer. A filter then treats any opposing direction pair (left with right, or up with down) that is pressed at the same time as released. A configuration input can switch this filter off.

A second register, the key control word, holds a key selection, an interrupt enable and a match mode. When the condition is met, the block raises a one-cycle interrupt request. In any-key mode the condition is that at least one selected key is pressed. In all-keys mode it is that every selected key is pressed. Writing the control word re-arms the edge detector, so a condition that still holds after the write produces a new pulse. The surrounding system reads the status word over the bus and forwards the pulse to its interrupt controller.

Top module: `keypad_status_unit`

## Requirements
- R1: After reset, the status word reads 0x03FF, the control word reads 0x0000 and `key_irq` is low.
- R2: The status word is 0x03FF XOR the filtered pressed vector, with bits 15:10 at zero. A change on `key_raw` (bit n high = key n pressed) appears on reads two clock edges later.
- R3: With `filter_bypass` low, when keys 4 and 5 (the horizontal pair) are both pressed, both report as released (status bits 4 and 5 read 1).
- R4: With `filter_bypass` low, when keys 6 and 7 (the vertical pair) are both pressed, both report as released.
- R5: Keys 0-3 and 8-9 pass through the filter unchanged, and a single pressed direction passes as well. With `filter_bypass` high, no key is suppressed.
- R6: A write to the control address (halfword index 1) stores the data ANDed with 0xC3FF. Reads return the stored value. Bits 9:0 select keys, bit 14 enables the interrupt and bit 15 selects all-keys mode.
- R7: A write to the status address (halfword index 0) changes neither the status word nor the control word.
- R8: In any-key mode (bit 15 = 0) with bit 14 set, pressing any selected key produces a pulse. With bit 14 clear, no pulse occurs.
- R9: In all-keys mode (bit 15 = 1), a pulse occurs only when every selected key is pressed. An empty selection never fires.
- R10: `key_irq` is high for exactly one cycle, one cycle after the condition becomes true. Holding the keys does not retrigger it.
- R11: A write to the control address re-evaluates the condition. If the condition holds with the new value, `key_irq` pulses in the cycle after the write takes effect, even if it was already true.
- R12: Reads from any address other than the two mapped ones return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_raw | input | 10 | Raw button lines, high = pressed |
| filter_bypass | input | 1 | High disables opposing-direction suppression |
| bus_addr | input | 4 | Halfword register index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| key_irq | output | 1 | One-cycle key interrupt request |

## Verification
The assertions assume that the write strobe, address and data are steady across each clock edge. They also assume that `filter_bypass` acts as a static configuration and changes only while no key is held. The stimulus changes every input just after a rising edge. It toggles the bypass only with the key lines released. It spaces control writes so that each pulse window can be observed on its own. The raw key lines may change at any edge, because the synchronizer is the only consumer of them.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

    localparam int KEY_COUNT = 10;
    localparam int REG_W     = 16;
    localparam int PAIR_COUNT = 2;

    localparam logic [REG_W-1:0] CTRL_MASK = 16'hC3FF;

    // Lower index of each opposing pair; the partner is the next bit.
    localparam int PAIR_BASE [PAIR_COUNT] = '{4, 6};

    typedef enum logic {
        MATCH_ANY = 1'b0,
        MATCH_ALL = 1'b1
    } match_mode_e;

    typedef struct packed {
        match_mode_e            mode;
        logic                   irq_en;
        logic [3:0]             pad;
        logic [KEY_COUNT-1:0]   select;
    } key_ctrl_t;

    function automatic logic [REG_W-1:0] status_word(input logic [KEY_COUNT-1:0] pressed);
        status_word = {{(REG_W-KEY_COUNT){1'b0}}, ~pressed};
    endfunction

    function automatic logic key_match(input key_ctrl_t c,
                                       input logic [KEY_COUNT-1:0] pressed);
        logic [KEY_COUNT-1:0] hit;
        hit = pressed & c.select;
        if (c.mode == MATCH_ALL)
            key_match = (c.select != '0) && (hit == c.select);
        else
            key_match = (hit != '0);
    endfunction

endpackage

// File: rtl/key_sync.sv
module key_sync #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= d;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/key_pair_filter.sv
module key_pair_filter #(
    parameter int WIDTH = 10,
    parameter int LO    = 4
) (
    input  logic             bypass,
    input  logic [WIDTH-1:0] in_keys,
    output logic [WIDTH-1:0] out_keys
);
    localparam int HI = LO + 1;

    logic clash;

    always_comb begin
        clash    = in_keys[LO] & in_keys[HI] & ~bypass;
        out_keys = in_keys;
        if (clash) begin
            out_keys[LO] = 1'b0;
            out_keys[HI] = 1'b0;
        end
    end
endmodule

// File: rtl/key_ctrl_regs.sv
module key_ctrl_regs
    import keypad_pkg::*;
#(
    parameter int               ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] STATUS_IDX = 4'd0,
    parameter logic [ADDR_W-1:0] CTRL_IDX   = 4'd1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic [KEY_COUNT-1:0] pressed,
    output logic [REG_W-1:0]     bus_rdata,
    output key_ctrl_t            ctrl,
    output logic                 ctrl_written
);
    key_ctrl_t ctrl_q;
    logic      wr_q;
    logic      ctrl_hit;

    assign ctrl_hit = bus_we && (bus_addr == CTRL_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            wr_q   <= 1'b0;
        end else begin
            wr_q <= ctrl_hit;
            if (ctrl_hit)
                ctrl_q <= key_ctrl_t'(bus_wdata & CTRL_MASK);
        end
    end

    always_comb begin
        unique case (bus_addr)
            STATUS_IDX: bus_rdata = status_word(pressed);
            CTRL_IDX:   bus_rdata = REG_W'(ctrl_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign ctrl         = ctrl_q;
    assign ctrl_written = wr_q;

    a_r6_masked_store: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit |=> (REG_W'(ctrl_q) == ($past(bus_wdata) & CTRL_MASK)));

    a_r7_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == STATUS_IDX) |=> $stable(ctrl_q));

    a_r11_write_flag: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit |=> ctrl_written);
endmodule

// File: rtl/key_irq_unit.sv
module key_irq_unit
    import keypad_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  key_ctrl_t            ctrl,
    input  logic                 ctrl_written,
    input  logic [KEY_COUNT-1:0] pressed,
    output logic                 irq
);
    logic cond;
    logic cond_prev;
    logic irq_q;

    always_comb begin
        cond = ctrl.irq_en && key_match(ctrl, pressed);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_prev <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            cond_prev <= cond;
            irq_q     <= cond && (!cond_prev || ctrl_written);
        end
    end

    assign irq = irq_q;

    a_r8_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ctrl.irq_en));

    a_r9_all_selected: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(ctrl.mode) == MATCH_ALL) |->
            (($past(pressed) & $past(ctrl.select)) == $past(ctrl.select)));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctrl_written) |=> !irq);
endmodule

// File: rtl/keypad_status_unit.sv
module keypad_status_unit
    import keypad_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int STATUS_IDX  = 0,
    parameter int CTRL_IDX    = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [KEY_COUNT-1:0] key_raw,
    input  logic                 filter_bypass,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic                 key_irq
);
    logic [KEY_COUNT-1:0] synced;
    logic [KEY_COUNT-1:0] chain [PAIR_COUNT+1];
    logic [KEY_COUNT-1:0] pressed;
    key_ctrl_t            ctrl;
    logic                 ctrl_written;

    key_sync #(.WIDTH(KEY_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (key_raw),
        .q   (synced)
    );

    assign chain[0] = synced;

    genvar p;
    generate
        for (p = 0; p < PAIR_COUNT; p++) begin : g_pair
            key_pair_filter #(.WIDTH(KEY_COUNT), .LO(PAIR_BASE[p])) u_filt (
                .bypass   (filter_bypass),
                .in_keys  (chain[p]),
                .out_keys (chain[p+1])
            );
        end
    endgenerate

    assign pressed = chain[PAIR_COUNT];

    key_ctrl_regs #(
        .ADDR_W     (ADDR_W),
        .STATUS_IDX (ADDR_W'(STATUS_IDX)),
        .CTRL_IDX   (ADDR_W'(CTRL_IDX))
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .pressed      (pressed),
        .bus_rdata    (bus_rdata),
        .ctrl         (ctrl),
        .ctrl_written (ctrl_written)
    );

    key_irq_unit u_irq (
        .clk          (clk),
        .rst          (rst),
        .ctrl         (ctrl),
        .ctrl_written (ctrl_written),
        .pressed      (pressed),
        .irq          (key_irq)
    );

    a_r3_horizontal_pair: assert property (@(posedge clk) disable iff (rst)
        (!filter_bypass && synced[4] && synced[5] && bus_addr == ADDR_W'(STATUS_IDX))
            |-> (bus_rdata[4] && bus_rdata[5]));

    a_r4_vertical_pair: assert property (@(posedge clk) disable iff (rst)
        (!filter_bypass && synced[6] && synced[7] && bus_addr == ADDR_W'(STATUS_IDX))
            |-> (bus_rdata[6] && bus_rdata[7]));

    a_r5_passthrough: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(STATUS_IDX))
            |-> ({bus_rdata[9:8], bus_rdata[3:0]} == ~{synced[9:8], synced[3:0]}));
endmodule

// File: tb/keypad_status_unit_bench.sv
module keypad_status_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  key_raw = '0;
    logic        filter_bypass = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        key_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        bit          is_irq;
        logic [15:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb[$];

    always #10 clk = ~clk;

    keypad_status_unit u_keypad_status_unit (
        .clk           (clk),
        .rst           (rst),
        .key_raw       (key_raw),
        .filter_bypass (filter_bypass),
        .bus_addr      (bus_addr),
        .bus_we        (bus_we),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .key_irq       (key_irq)
    );

    // Monitor: compares one expected item per cycle at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_item_t it;
            logic [15:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {15'd0, key_irq} : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input bit is_irq, input logic [15:0] exp, input string tag);
        exp_item_t it;
        it.is_irq = is_irq;
        it.exp    = exp;
        it.tag    = tag;
        sb.push_back(it);
    endtask

    task automatic check_rd(input logic [3:0] addr, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = addr;
        push(1'b0, exp, tag);
    endtask

    task automatic step_irq(input bit exp, input string tag);
        @(posedge clk); #1;
        push(1'b1, {15'd0, exp}, tag);
    endtask

    task automatic write_reg(input logic [3:0] addr, input logic [15:0] data);
        @(posedge clk); #1;
        bus_addr  = addr;
        bus_wdata = data;
        bus_we    = 1'b1;
        @(posedge clk); #1;
        bus_we    = 1'b0;
    endtask

    task automatic set_keys(input logic [9:0] v);
        @(posedge clk); #1;
        key_raw = v;
    endtask

    // Sets keys and checks the status word once the synchronizer has passed them.
    task automatic keys_status(input logic [9:0] v, input logic [15:0] exp, input string tag);
        set_keys(v);
        @(posedge clk);
        check_rd(4'd0, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check_rd(4'd0, 16'h03FF, "R1 status after reset");
        check_rd(4'd1, 16'h0000, "R1 control after reset");
        step_irq(1'b0, "R1 irq after reset");

        // R2: plain inversion
        keys_status(10'h001, 16'h03FE, "R2 key0 pressed");
        keys_status(10'h30F, 16'h00F0, "R2 mixed keys");

        // R3 / R4: opposing pairs suppressed
        keys_status(10'h030, 16'h03FF, "R3 left+right suppressed");
        keys_status(10'h031, 16'h03FE, "R3 pair with key0");
        keys_status(10'h0C0, 16'h03FF, "R4 up+down suppressed");
        keys_status(10'h0F3, 16'h03FC, "R4 all directions with keys 0,1");

        // R5: passthrough and bypass
        keys_status(10'h3FF, 16'h00F0, "R5 all pressed filtered");
        keys_status(10'h020, 16'h03DF, "R5 single direction passes");
        keys_status(10'h000, 16'h03FF, "R5 released");
        filter_bypass = 1'b1;
        keys_status(10'h3FF, 16'h0000, "R5 all pressed bypass");
        keys_status(10'h000, 16'h03FF, "R5 released bypass");
        filter_bypass = 1'b0;

        // R6: mask on control writes
        write_reg(4'd1, 16'hFFFF);
        check_rd(4'd1, 16'hC3FF, "R6 mask all ones");
        write_reg(4'd1, 16'h3C00);
        check_rd(4'd1, 16'h0000, "R6 reserved bits dropped");
        write_reg(4'd1, 16'h0123);

        // R7: status writes ignored
        write_reg(4'd0, 16'h0000);
        check_rd(4'd0, 16'h03FF, "R7 status unchanged");
        check_rd(4'd1, 16'h0123, "R7 control unchanged");

        // R12: unmapped read
        check_rd(4'd5, 16'h0000, "R12 unmapped index 5");
        check_rd(4'd15, 16'h0000, "R12 unmapped index 15");

        // R8 / R10: any mode, enabled, keys 0 and 1
        write_reg(4'd1, 16'h4003);
        step_irq(1'b0, "R8 no keys no irq");
        set_keys(10'h002);
        step_irq(1'b0, "R10 sync stage 1");
        step_irq(1'b0, "R10 sync stage 2");
        step_irq(1'b1, "R8 any-mode pulse");
        step_irq(1'b0, "R10 pulse ends");
        step_irq(1'b0, "R10 held no retrigger");
        set_keys(10'h000);
        repeat (3) step_irq(1'b0, "R10 release quiet");

        // R8: disabled
        write_reg(4'd1, 16'h0003);
        set_keys(10'h001);
        repeat (5) step_irq(1'b0, "R8 disabled no irq");
        set_keys(10'h000);
        repeat (3) @(posedge clk);

        // R9: all mode
        write_reg(4'd1, 16'hC003);
        set_keys(10'h001);
        repeat (5) step_irq(1'b0, "R9 partial no irq");
        set_keys(10'h003);
        step_irq(1'b0, "R9 sync stage 1");
        step_irq(1'b0, "R9 sync stage 2");
        step_irq(1'b1, "R9 all pressed pulse");
        step_irq(1'b0, "R10 all-mode pulse ends");

        // R11: rewrite while condition holds
        write_reg(4'd1, 16'hC003);
        step_irq(1'b1, "R11 rewrite re-fires");
        step_irq(1'b0, "R11 single pulse after rewrite");

        // R9: empty selection never fires
        write_reg(4'd1, 16'hC000);
        repeat (3) step_irq(1'b0, "R9 empty select");
        set_keys(10'h000);

        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule